// File: doc/BRIEF.md
# Configurable Serial Transmit/Receive Channel

This block is a full-duplex serial channel with two framings, chosen by a four-bit mode register. In asynchronous framing the transmitter sends a low start bit, then 7 or 8 data bits LSB first, then an optional parity bit, then a high stop bit. The receiver recovers such frames with 16x oversampling driven by an external baud tick. In synchronous framing both sides move plain 8-bit frames, LSB first. The transmitter drives its own serial clock. Data changes on the clock's falling edge, and the receiver takes a bit on each rising edge of the incoming clock. In synchronous framing the length and parity bits of the mode register are ignored.

Bytes enter through a valid/ready transmit port. `tx_ready` is high only while the transmitter is idle, and a byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. The sender must hold `tx_valid` and `tx_data` until that edge.

Received bytes leave through a valid/ready port backed by a single holding register. `rx_valid` stays high with `rx_data` unchanged until a cycle with `rx_ready` high. A frame that completes while the holding register is still full is dropped, even if the register is emptied in that same cycle.

Parity and framing errors are sticky flags. The host clears them by writing 0 to the flag bits.

Top module: `serial_chan`

## Requirements
- R1: After reset, `mode_q` is 0 (asynchronous, 8-bit, parity off, even parity). Both error flags are low, `txd` and `sclk_out` are high, `tx_ready` is high and `rx_valid` is low.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the mode register, and `mode_q` shows it from the next cycle. The field map is: bit0 = synchronous framing, bit1 = 7-bit characters, bit2 = parity enable, bit3 = odd parity.
- R3: In asynchronous framing a frame is one low start bit, the data bits LSB first, the parity bit when enabled, and one high stop bit. There are 7 data bits when bit1 is set and 8 otherwise; in 7-bit mode bit 7 of the byte is not sent. Each bit lasts OSR baud ticks, and the line idles high.
- R4: With even parity (bit3 = 0) the sent data bits plus the parity bit hold an even number of ones. With odd parity (bit3 = 1) they hold an odd number.
- R5: In synchronous framing a frame is exactly 8 data bits LSB first, with no start, stop or parity bit, whatever bits 1 to 3 hold. `sclk_out` is low for the first OSR/2 ticks of each bit and high for the rest, and it idles high.
- R6: The asynchronous receiver takes a start bit after OSR/2 low samples and samples every later bit at its centre. It delivers the data bits on `rx_data`, and in 7-bit mode `rx_data[7]` is 0.
- R7: With parity enabled, a received parity bit that breaks the selected rule sets `parity_err`. With parity disabled, `parity_err` is never set.
- R8: A stop bit sampled low sets `frame_err`. The data byte is still delivered.
- R9: A cycle with `flag_we` high clears `parity_err` when `flag_wdata[0]` is 0 and clears `frame_err` when `flag_wdata[1]` is 0. Writing 1 to a flag bit leaves that flag unchanged.
- R10: In synchronous framing the receiver samples `rxd` on each rising edge of `sclk_in` and delivers a byte after every 8 bits, LSB first.
- R11: `tx_ready` goes low on the edge that takes a byte. It stays low for the whole frame and returns high once the last bit has lasted its full OSR ticks.
- R12: `rx_valid` with `rx_data` held stable stays high until `rx_ready` is seen. A frame that completes while `rx_valid` is high is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One pulse per oversampling tick (OSR ticks per bit) |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 4 | Mode value to write |
| mode_q | output | 4 | Current mode register |
| flag_we | input | 1 | Error flag write strobe |
| flag_wdata | input | 2 | Flag write value; a 0 clears (bit0 parity, bit1 framing) |
| parity_err | output | 1 | Sticky parity error |
| frame_err | output | 1 | Sticky framing error |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmitter idle, will take a byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| txd | output | 1 | Serial data out |
| sclk_out | output | 1 | Serial clock out (synchronous framing) |
| rxd | input | 1 | Serial data in |
| sclk_in | input | 1 | Serial clock in (synchronous framing) |

## Verification
The bench builds the block with its default OSR of 16 and two synchronizer stages, and holds the baud tick high so that every bit lasts exactly 16 clocks. At that size it can sweep all sixteen mode register values, each with edge-case and mixed bytes. It compares `txd` and `sclk_out` against arithmetically built frames at fixed offsets inside each bit, and checks the looped-back byte that arrives. Hand-built line waveforms with a wrong parity bit and with a low stop bit reach the error flags and their clear rule. Two back-to-back frames sent without popping reach the single-register drop rule.

// File: rtl/serial_chan_pkg.sv
package serial_chan_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic chr7;
    logic sync;
  } mode_t;

  function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic chr7,
                                   input logic odd);
    logic p;
    p = chr7 ? ^d[DATA_W-2:0] : ^d;
    return p ^ odd;
  endfunction
endpackage

// File: rtl/serial_chan_sync.sv
module serial_chan_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/serial_chan_tx.sv
module serial_chan_tx
  import serial_chan_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  mode_t             mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              txd,
  output logic              sclk
);
  localparam int CNT_W   = $clog2(OSR);
  localparam int FRAME_W = DATA_W + 3;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic               busy, snc, load;
  logic [FRAME_W-1:0] frame, fr_next;
  logic [LEN_W-1:0]   left, len_next, nbits;
  logic [CNT_W-1:0]   tcnt;

  assign in_ready = !busy;
  assign load     = in_valid && !busy;

  // Build the whole frame at load time; stop and trailing bits default to 1.
  always_comb begin
    fr_next  = '1;
    nbits    = mode.chr7 ? LEN_W'(DATA_W - 1) : LEN_W'(DATA_W);
    len_next = LEN_W'(DATA_W);
    if (mode.sync) begin
      fr_next[DATA_W-1:0] = in_data;
    end else begin
      fr_next[0]        = 1'b0;
      fr_next[DATA_W:1] = in_data;
      if (mode.chr7) fr_next[DATA_W] = 1'b1;
      if (mode.par_en)
        fr_next[nbits + LEN_W'(1)] = par_bit(in_data, mode.chr7, mode.par_odd);
      len_next = nbits + LEN_W'(2) + LEN_W'(mode.par_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      snc   <= 1'b0;
      frame <= '1;
      left  <= '0;
      tcnt  <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      snc   <= mode.sync;
      frame <= fr_next;
      left  <= len_next;
      tcnt  <= '0;
    end else if (busy && tick) begin
      if (tcnt == CNT_W'(OSR - 1)) begin
        tcnt  <= '0;
        frame <= {1'b1, frame[FRAME_W-1:1]};
        left  <= left - LEN_W'(1);
        if (left == LEN_W'(1)) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + CNT_W'(1);
      end
    end
  end

  assign txd  = busy ? frame[0] : 1'b1;
  assign sclk = !(busy && snc) || (tcnt >= CNT_W'(OSR / 2));
endmodule

// File: rtl/serial_chan_rx.sv
module serial_chan_rx
  import serial_chan_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  mode_t             mode,
  input  logic              mode_wr,
  input  logic              rxd,
  input  logic              sclk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              perr_set,
  output logic              ferr_set
);
  localparam int CNT_W = $clog2(OSR);

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rx_st_e;

  rx_st_e            st;
  logic [CNT_W-1:0]  tcnt;
  logic [3:0]        idx, nb;
  mode_t             am;
  logic [DATA_W-1:0] sh, ssh;
  logic [2:0]        sidx;
  logic              pbit, sclk_d;

  assign nb = am.chr7 ? 4'd7 : 4'd8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= R_IDLE;
      tcnt      <= '0;
      idx       <= '0;
      am        <= '0;
      sh        <= '0;
      ssh       <= '0;
      sidx      <= '0;
      pbit      <= 1'b0;
      sclk_d    <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
      perr_set  <= 1'b0;
      ferr_set  <= 1'b0;
    end else begin
      perr_set <= 1'b0;
      ferr_set <= 1'b0;
      sclk_d   <= sclk;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (mode_wr) begin
        st   <= R_IDLE;
        sidx <= '0;
      end else begin
        // asynchronous receive
        case (st)
          R_IDLE: if (tick && !mode.sync && !rxd) begin
            st   <= R_START;
            tcnt <= '0;
          end
          R_START: if (tick) begin
            if (rxd) st <= R_IDLE;
            else if (tcnt == CNT_W'(OSR / 2 - 2)) begin
              st   <= R_BITS;
              tcnt <= '0;
              idx  <= '0;
              am   <= mode;
              sh   <= '0;
            end else tcnt <= tcnt + CNT_W'(1);
          end
          R_BITS: if (tick) begin
            if (tcnt != CNT_W'(OSR - 1)) tcnt <= tcnt + CNT_W'(1);
            else begin
              tcnt <= '0;
              idx  <= idx + 4'd1;
              if (idx < nb) sh[idx[2:0]] <= rxd;
              else if (am.par_en && idx == nb) pbit <= rxd;
              else begin
                st       <= R_IDLE;
                ferr_set <= !rxd;
                perr_set <= am.par_en && (pbit != par_bit(sh, am.chr7, am.par_odd));
                if (!out_valid) begin
                  out_valid <= 1'b1;
                  out_data  <= am.chr7 ? {1'b0, sh[DATA_W-2:0]} : sh;
                end
              end
            end
          end
          default: st <= R_IDLE;
        endcase
        // synchronous receive
        if (mode.sync && sclk && !sclk_d) begin
          ssh[sidx] <= rxd;
          sidx      <= sidx + 3'd1;
          if (sidx == 3'd7 && !out_valid) begin
            out_valid <= 1'b1;
            out_data  <= {rxd, ssh[DATA_W-2:0]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_chan.sv
module serial_chan
  import serial_chan_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baud_tick,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_wdata,
  output logic [3:0]  mode_q,
  input  logic        flag_we,
  input  logic [1:0]  flag_wdata,
  output logic        parity_err,
  output logic        frame_err,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [7:0]  tx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic [7:0]  rx_data,
  output logic        txd,
  output logic        sclk_out,
  input  logic        rxd,
  input  logic        sclk_in
);
  mode_t mode;
  logic  perr_set, ferr_set, rxd_s, sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= '0;
    else if (cfg_we) mode <= mode_t'(cfg_wdata);
  end
  assign mode_q = mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      if (perr_set) parity_err <= 1'b1;
      else if (flag_we && !flag_wdata[0]) parity_err <= 1'b0;
      if (ferr_set) frame_err <= 1'b1;
      else if (flag_we && !flag_wdata[1]) frame_err <= 1'b0;
    end
  end

  serial_chan_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk_in, rxd}), .q({sclk_s, rxd_s})
  );

  serial_chan_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .mode(mode),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .txd(txd), .sclk(sclk_out)
  );

  serial_chan_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .mode(mode), .mode_wr(cfg_we),
    .rxd(rxd_s), .sclk(sclk_s), .out_valid(rx_valid), .out_ready(rx_ready),
    .out_data(rx_data), .perr_set(perr_set), .ferr_set(ferr_set)
  );
endmodule

// File: rtl/serial_chan_chk.sv
module serial_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       sclk_out,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       parity_err,
  input logic       frame_err,
  input logic       flag_we,
  input logic [1:0] flag_wdata
);
  // R3
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);
  // R5
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> sclk_out);
  // R11
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  // R9
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err && !(flag_we && !flag_wdata[0]) |=> parity_err);
  // R9
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !(flag_we && !flag_wdata[1]) |=> frame_err);
endmodule

bind serial_chan serial_chan_chk u_chk (.*);

// File: tb/tb_serial_chan.sv
`timescale 1ns/1ps
module tb_serial_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, flag_we = 0, tx_valid = 0, rx_ready = 0;
  logic [3:0] cfg_wdata = 0;
  logic [1:0] flag_wdata = 0;
  logic [7:0] tx_data = 0;
  logic loop = 1'b1, drv_rxd = 1'b1, drv_sclk = 1'b1;
  logic [3:0] mode_q;
  logic parity_err, frame_err, tx_ready, rx_valid, txd, sclk_out;
  logic [7:0] rx_data;
  logic rxd_w, sclk_w;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;
  assign rxd_w  = loop ? txd : drv_rxd;
  assign sclk_w = loop ? sclk_out : drv_sclk;

  serial_chan dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_q(mode_q), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .parity_err(parity_err), .frame_err(frame_err), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .txd(txd), .sclk_out(sclk_out), .rxd(rxd_w), .sclk_in(sclk_w)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk); cfg_we = 1; cfg_wdata = m;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic write_flags(input logic [1:0] v);
    @(negedge clk); flag_we = 1; flag_wdata = v;
    @(negedge clk); flag_we = 0;
  endtask

  task automatic exp_frame(input logic [7:0] d, input logic [3:0] m,
                           output logic [10:0] f, output int n, output int pidx);
    int nb, ones, k;
    f = '1; pidx = -1;
    if (m[0]) begin
      f[7:0] = d; n = 8;
    end else begin
      nb = m[1] ? 7 : 8;
      f[0] = 1'b0;
      for (int i = 0; i < nb; i++) f[i+1] = d[i];
      k = nb + 1;
      if (m[2]) begin
        ones = $countones(m[1] ? (d & 8'h7f) : d);
        f[k] = m[3] ? ~ones[0] : ones[0];
        pidx = k; k++;
      end
      f[k] = 1'b1;
      n = k + 1;
    end
  endtask

  task automatic send_tx(input logic [7:0] d, input logic [3:0] m);
    logic [10:0] f; int n, pidx, cur; string base, tag;
    exp_frame(d, m, f, n, pidx);
    base = m[0] ? "R5" : "R3";
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = d;
    @(posedge clk); @(negedge clk);
    tx_valid = 0; cur = 0;
    chk(tx_ready == 0, "R11", tx_ready, 0);
    for (int i = 0; i < n; i++) begin
      tag = (i == pidx) ? "R4" : base;
      repeat (16*i + 4 - cur) @(negedge clk); cur = 16*i + 4;
      chk(txd == f[i], tag, txd, f[i]);
      if (m[0]) chk(sclk_out == 0, "R5", sclk_out, 0);
      repeat (8) @(negedge clk); cur += 8;
      chk(txd == f[i], tag, txd, f[i]);
      if (m[0]) chk(sclk_out == 1, "R5", sclk_out, 1);
    end
    repeat (16*n - 1 - cur) @(negedge clk);
    chk(tx_ready == 0, "R11", tx_ready, 0);
    repeat (2) @(negedge clk);
    chk(tx_ready == 1 && txd == 1, base, {tx_ready, txd}, 3);
  endtask

  task automatic wait_rx();
    for (int i = 0; i < 200 && !rx_valid; i++) @(negedge clk);
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
    chk(rx_valid == 0, "R12", rx_valid, 0);
  endtask

  task automatic recv_chk(input logic [7:0] exp, input string tag);
    wait_rx();
    chk(rx_valid == 1, tag, rx_valid, 1);
    chk(rx_data == exp, tag, rx_data, exp);
    chk(parity_err == 0, "R7", parity_err, 0);
    chk(frame_err == 0, "R8", frame_err, 0);
    pop_rx();
  endtask

  task automatic drive_bits(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); drv_rxd = f[i];
      repeat ((i == n - 1) ? 9 : 15) @(negedge clk);
    end
    @(negedge clk); drv_rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] vals [10];
    logic [3:0] m;
    logic [10:0] f;
    vals = '{8'h00, 8'hff, 8'ha5, 8'h5a, 8'h80, 8'h01, 8'h7f, 8'hfe, 8'h3c, 8'hc3};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(mode_q == 0, "R1", mode_q, 0);
    chk(parity_err == 0 && frame_err == 0, "R1", {parity_err, frame_err}, 0);
    chk(txd == 1 && sclk_out == 1, "R1", {txd, sclk_out}, 3);
    chk(tx_ready == 1 && rx_valid == 0, "R1", {tx_ready, rx_valid}, 2);
    // R2
    set_mode(4'b1010);
    chk(mode_q == 4'hA, "R2", mode_q, 4'hA);
    // asynchronous sweep: R3 R4 R6 R7
    for (int c = 0; c < 8; c++) begin
      m = {c[2:0], 1'b0};
      set_mode(m);
      chk(mode_q == m, "R2", mode_q, m);
      for (int v = 0; v < 10; v++) begin
        send_tx(vals[v], m);
        recv_chk(m[1] ? (vals[v] & 8'h7f) : vals[v], "R6");
      end
    end
    // synchronous sweep: R5 R10 (length/parity bits ignored)
    for (int c = 0; c < 8; c++) begin
      m = {c[2:0], 1'b1};
      set_mode(m);
      for (int v = 0; v < 5; v++) begin
        send_tx(vals[v], m);
        recv_chk(vals[v], "R10");
      end
    end
    // R12: second frame dropped while holding register full
    set_mode(4'b0000);
    send_tx(8'h11, 4'b0000);
    send_tx(8'h22, 4'b0000);
    repeat (40) @(negedge clk);
    chk(rx_valid == 1 && rx_data == 8'h11, "R12", rx_data, 8'h11);
    pop_rx();
    // R7: bad parity, even parity, 8-bit
    loop = 0;
    set_mode(4'b0100);
    f = 11'b11_0000_0011_0; // stop, wrong parity 1, data 0x03, start
    drive_bits(f, 11);
    wait_rx();
    chk(rx_data == 8'h03, "R6", rx_data, 8'h03);
    chk(parity_err == 1, "R7", parity_err, 1);
    chk(frame_err == 0, "R8", frame_err, 0);
    pop_rx();
    // R9
    write_flags(2'b11);
    chk(parity_err == 1, "R9", parity_err, 1);
    write_flags(2'b10);
    chk(parity_err == 0, "R9", parity_err, 0);
    // R8: low stop bit
    set_mode(4'b0000);
    f = 11'b10_0101_0101_0; // bit9 stop low
    drive_bits(f, 10);
    wait_rx();
    chk(rx_data == 8'h55, "R8", rx_data, 8'h55);
    chk(frame_err == 1, "R8", frame_err, 1);
    chk(parity_err == 0, "R7", parity_err, 0);
    pop_rx();
    write_flags(2'b11);
    chk(frame_err == 1, "R9", frame_err, 1);
    write_flags(2'b01);
    chk(frame_err == 0, "R9", frame_err, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule